// File: doc/BRIEF.md
# Write-Once Byte Memory Mode Decoder

This block is a synthesizable behavioural model of a byte-wide memory that can be programmed once and erased in bulk. It is meant to sit in front of a memory controller under test. The controller drives the same signals it would drive to a real part: an address, an active-low chip enable, an active-low output enable and an active-low program strobe. Two abstract flags stand in for the analog levels. One says the programming supply is raised. The other says a high voltage is present on the signature address line. The model decodes these inputs into one of seven operating modes and reports that mode on a status output. It drives the data bus only in the modes that return data, and it writes a byte only through the programming sequence.

Storage is parameterized in depth and is held in flops. After reset or an erase request every bit is 1. Programming can only clear bits: the stored word becomes the old word AND the data presented. The outputs are combinational from the inputs and the stored words. The only clocked behaviour is the write and the erase.

Top module: `otp_eprom_model`

## Requirements
- R1: After reset, and in the clock cycle after `erase_i` is sampled high at a rising clock edge, every location reads 0xFF. An erase takes priority over a write at the same edge.
- R2: A write stores old AND new. Without an erase, no stored bit ever goes from 0 to 1.
- R3: With `ce_n_i`=0, `oe_n_i`=0, `pgm_n_i`=1, `vpp_hi_i`=0 and `a9_hv_i`=0, the mode is READ (code 0), `dq_oe_o`=1, and `dq_o` is the byte stored at `addr_i`.
- R4: With `ce_n_i`=0 and `oe_n_i`=1, the mode is DISABLE (code 1) and `dq_oe_o`=0, unless the program condition of R6 holds. Whenever `dq_oe_o`=0, `dq_o` is 0x00.
- R5: With `ce_n_i`=1 the outputs are not driven. The mode is STANDBY (code 2) when `vpp_hi_i`=0 and INHIBIT (code 5) when `vpp_hi_i`=1, and no write takes place whatever `pgm_n_i` does.
- R6: With `ce_n_i`=0, `oe_n_i`=1, `vpp_hi_i`=1 and `pgm_n_i`=0, the mode is PROGRAM (code 3). A write happens at a rising clock edge when three things hold: the mode sampled at the previous edge was PROGRAM, and now `pgm_n_i`=1, `ce_n_i`=0 and `vpp_hi_i`=1. The write uses the `addr_i` and `dq_i` present at that edge.
- R7: With `ce_n_i`=0, `oe_n_i`=0, `pgm_n_i`=1 and `vpp_hi_i`=1, the mode is VERIFY (code 4) and the stored byte is driven.
- R8: With `ce_n_i`=0, `oe_n_i`=0, `pgm_n_i`=1, `vpp_hi_i`=0 and `a9_hv_i`=1, the mode is SIGNATURE (code 6). The block drives 0x20 when `addr_i[0]`=0 and 0x61 when `addr_i[0]`=1.
- R9: `ce_n_i`=0 with `oe_n_i`=0 and `pgm_n_i`=0 is illegal. It decodes as DISABLE with no drive, and it does not arm a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write and erase |
| rst_n | input | 1 | Asynchronous active-low reset; fills the array with ones |
| erase_i | input | 1 | Synchronous bulk erase to all ones |
| addr_i | input | ADDR_W | Byte address |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| pgm_n_i | input | 1 | Program strobe, active low |
| vpp_hi_i | input | 1 | Programming supply raised |
| a9_hv_i | input | 1 | High voltage on the signature address line |
| dq_i | input | DATA_W | Data presented for programming |
| dq_o | output | DATA_W | Data driven out (0 when not driven) |
| dq_oe_o | output | 1 | Data bus drive enable |
| mode_o | output | 3 | Current operating mode code |

## Verification
Directed sequences run first. They program one address twice with overlapping patterns to show the AND rule. They also pulse the strobe with chip enable high, which should not write, and pulse it with output enable low, which is illegal. The random phase draws every control bit and flag freely over a narrow address window, so that program, verify and read keep landing on the same bytes. Erases fall in now and then, and some coincide with write edges. A bench model predicts the mode, the drive enable and the data every cycle. This tells apart decode priority errors, such as verify against signature or program against disable, from errors in when a write fires or what it stores.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
   typedef enum logic [2:0] {
      MODE_READ      = 3'd0,
      MODE_DISABLE   = 3'd1,
      MODE_STANDBY   = 3'd2,
      MODE_PROGRAM   = 3'd3,
      MODE_VERIFY    = 3'd4,
      MODE_INHIBIT   = 3'd5,
      MODE_SIGNATURE = 3'd6
   } eprom_mode_e;

   function automatic logic mode_drives(eprom_mode_e m);
      return (m == MODE_READ) || (m == MODE_VERIFY) || (m == MODE_SIGNATURE);
   endfunction
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
   import eprom_pkg::*;
(
   input  logic        ce_n,
   input  logic        oe_n,
   input  logic        pgm_n,
   input  logic        vpp_hi,
   input  logic        a9_hv,
   output eprom_mode_e mode
);
   always_comb begin
      if (ce_n) begin
         mode = vpp_hi ? MODE_INHIBIT : MODE_STANDBY;
      end else if (oe_n) begin
         mode = (vpp_hi && !pgm_n) ? MODE_PROGRAM : MODE_DISABLE;
      end else if (!pgm_n) begin
         mode = MODE_DISABLE;
      end else if (vpp_hi) begin
         mode = MODE_VERIFY;
      end else if (a9_hv) begin
         mode = MODE_SIGNATURE;
      end else begin
         mode = MODE_READ;
      end
   end
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[g] <= ALL_ONES;
         end else if (erase) begin
            words[g] <= ALL_ONES;
         end else if (hit) begin
            words[g] <= words[g] & wr_data;
         end
      end

      // R2
      bits_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !erase |=> ((words[g] & ~$past(words[g])) == '0));
   end

   assign rd_data = words[rd_addr];
endmodule

// File: rtl/eprom_out_mux.sv
module eprom_out_mux
   import eprom_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] MFR_CODE  = 8'h20,
   parameter logic [DATA_W-1:0] DEV_CODE  = 8'h61,
   parameter bit                IDLE_ZERO = 1'b1
) (
   input  eprom_mode_e       mode,
   input  logic              sel_dev,
   input  logic [DATA_W-1:0] cell_data,
   output logic [DATA_W-1:0] dq,
   output logic              dq_oe
);
   logic [DATA_W-1:0] active_val;

   assign dq_oe      = mode_drives(mode);
   assign active_val = (mode == MODE_SIGNATURE) ? (sel_dev ? DEV_CODE : MFR_CODE)
                                                : cell_data;

   if (IDLE_ZERO) begin : g_idle_zero
      assign dq = dq_oe ? active_val : '0;
   end else begin : g_idle_pass
      assign dq = active_val;
   end
endmodule

// File: rtl/otp_eprom_model.sv
module otp_eprom_model
   import eprom_pkg::*;
#(
   parameter int                ADDR_W   = 6,
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'h20,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'h61
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   input  logic              pgm_n_i,
   input  logic              vpp_hi_i,
   input  logic              a9_hv_i,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe_o,
   output logic [2:0]        mode_o
);
   initial begin
      if (ADDR_W < 1 || ADDR_W > 10) $error("otp_eprom_model: ADDR_W out of range");
      if (DATA_W != 8) $error("otp_eprom_model: DATA_W must be 8");
   end

   eprom_mode_e       mode;
   logic              armed_q;
   logic              wr_en;
   logic [DATA_W-1:0] cell_data;

   eprom_mode_dec u_dec (
      .ce_n   (ce_n_i),
      .oe_n   (oe_n_i),
      .pgm_n  (pgm_n_i),
      .vpp_hi (vpp_hi_i),
      .a9_hv  (a9_hv_i),
      .mode   (mode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= (mode == MODE_PROGRAM);
   end

   assign wr_en = armed_q && pgm_n_i && !ce_n_i && vpp_hi_i;

   eprom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .erase   (erase_i),
      .wr_en   (wr_en),
      .wr_addr (addr_i),
      .wr_data (dq_i),
      .rd_addr (addr_i),
      .rd_data (cell_data)
   );

   eprom_out_mux #(
      .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE), .IDLE_ZERO(1'b1)
   ) u_mux (
      .mode      (mode),
      .sel_dev   (addr_i[0]),
      .cell_data (cell_data),
      .dq        (dq_o),
      .dq_oe     (dq_oe_o)
   );

   assign mode_o = mode;

   // R6
   write_after_strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (pgm_n_i && !$past(pgm_n_i) && $past(vpp_hi_i)));

   // R5
   no_drive_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n_i |-> (!dq_oe_o && !wr_en));

   // R4
   idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe_o |-> (dq_o == '0));

   // R8
   signature_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd6) |-> (dq_oe_o && (dq_o == MFR_CODE || dq_o == DEV_CODE)));

   // R9
   illegal_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n_i && !oe_n_i && !pgm_n_i) |-> (!dq_oe_o && mode_o == 3'd1));
endmodule

// File: tb/otp_eprom_model_tb.sv
module otp_eprom_model_tb_top;
   localparam int AW = 6;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          erase_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          ce_n_i = 1'b1, oe_n_i = 1'b1, pgm_n_i = 1'b1;
   logic          vpp_hi_i = 1'b0, a9_hv_i = 1'b0;
   logic [7:0]    dq_i = '0;
   logic [7:0]    dq_o;
   logic          dq_oe_o;
   logic [2:0]    mode_o;

   int total = 0;
   int bad = 0;
   logic [7:0] ref_mem [DEPTH];
   logic       ref_armed = 1'b0;

   always #4 clk = ~clk;

   otp_eprom_model #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .erase_i(erase_i), .addr_i(addr_i),
      .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .pgm_n_i(pgm_n_i), .vpp_hi_i(vpp_hi_i),
      .a9_hv_i(a9_hv_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .mode_o(mode_o)
   );

   function automatic logic [2:0] exp_mode(logic ce, logic oe, logic pg, logic vp, logic hv);
      if (ce) return vp ? 3'd5 : 3'd2;
      if (oe) return (vp && !pg) ? 3'd3 : 3'd1;
      if (!pg) return 3'd1;
      if (vp) return 3'd4;
      if (hv) return 3'd6;
      return 3'd0;
   endfunction

   function automatic logic [7:0] exp_data(logic [2:0] m, logic [7:0] stored, logic a0);
      if (m == 3'd6) return a0 ? 8'h61 : 8'h20;
      if (m == 3'd0 || m == 3'd4) return stored;
      return 8'h00;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // compare all outputs against the bench model; tag names the requirement in focus
   task automatic check_outputs(string req);
      logic [2:0] m;
      m = exp_mode(ce_n_i, oe_n_i, pgm_n_i, vpp_hi_i, a9_hv_i);
      check({req, " mode"}, 32'(mode_o), 32'(m));
      check({req, " oe"}, 32'(dq_oe_o), 32'(m == 3'd0 || m == 3'd4 || m == 3'd6));
      check({req, " data"}, 32'(dq_o), 32'(exp_data(m, ref_mem[addr_i], addr_i[0])));
   endtask

   // one clock: inputs held since the falling edge, model updated at the rising edge
   task automatic tick();
      @(posedge clk);
      if (erase_i) begin
         for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
      end else if (ref_armed && pgm_n_i && !ce_n_i && vpp_hi_i) begin
         ref_mem[addr_i] = ref_mem[addr_i] & dq_i;
      end
      ref_armed = (exp_mode(ce_n_i, oe_n_i, pgm_n_i, vpp_hi_i, a9_hv_i) == 3'd3);
      @(negedge clk);
   endtask

   task automatic set_pins(logic ce, logic oe, logic pg, logic vp, logic hv,
                           logic [AW-1:0] a, logic [7:0] d);
      ce_n_i = ce; oe_n_i = oe; pgm_n_i = pg; vpp_hi_i = vp; a9_hv_i = hv;
      addr_i = a; dq_i = d;
      #2;
   endtask

   task automatic program_byte(logic [AW-1:0] a, logic [7:0] d);
      set_pins(0, 1, 0, 1, 0, a, d);
      check_outputs("R6");
      tick();
      set_pins(0, 1, 1, 1, 0, a, d);
      check_outputs("R4");
      tick();
   endtask

   task automatic read_at(string req, logic [AW-1:0] a, logic [7:0] exp);
      set_pins(0, 0, 1, 0, 0, a, 8'h00);
      check_outputs(req);
      check({req, " direct"}, 32'(dq_o), 32'(exp));
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
      #200000;
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R5 reset state: deselected, standby
      check("R5 reset mode", 32'(mode_o), 32'd2);
      check("R5 reset oe", 32'(dq_oe_o), 32'd0);
      // R1 after reset everything reads ones
      read_at("R1", 6'd0, 8'hFF);
      read_at("R1", 6'd63, 8'hFF);

      // R6 R3 program and read back
      program_byte(6'd5, 8'hA5);
      read_at("R3", 6'd5, 8'hA5);
      read_at("R3", 6'd4, 8'hFF);
      // R2 second write only clears
      program_byte(6'd5, 8'h5F);
      read_at("R2", 6'd5, 8'h05);
      program_byte(6'd5, 8'hFF);
      read_at("R2", 6'd5, 8'h05);

      // R6 address and data taken at the rising-strobe edge
      set_pins(0, 1, 0, 1, 0, 6'd9, 8'h00);
      tick();
      set_pins(0, 1, 1, 1, 0, 6'd10, 8'h3C);
      tick();
      read_at("R6", 6'd9, 8'hFF);
      read_at("R6", 6'd10, 8'h3C);

      // R7 verify
      set_pins(0, 0, 1, 1, 0, 6'd10, 8'h00);
      check_outputs("R7");
      check("R7 direct", 32'(dq_o), 32'h3C);

      // R8 signature both codes
      set_pins(0, 0, 1, 0, 1, 6'd2, 8'h00);
      check_outputs("R8");
      check("R8 mfr", 32'(dq_o), 32'h20);
      set_pins(0, 0, 1, 0, 1, 6'd3, 8'h00);
      check("R8 dev", 32'(dq_o), 32'h61);

      // R4 output disable
      set_pins(0, 1, 1, 0, 0, 6'd10, 8'h00);
      check_outputs("R4");
      check("R4 bus zero", 32'(dq_o), 32'h00);

      // R5 strobe pulse while deselected: no write
      set_pins(1, 1, 0, 1, 0, 6'd20, 8'h00);
      check("R5 inhibit", 32'(mode_o), 32'd5);
      tick();
      set_pins(1, 1, 1, 1, 0, 6'd20, 8'h00);
      tick();
      read_at("R5", 6'd20, 8'hFF);

      // R9 illegal strobe with output enable low: no drive, no write
      set_pins(0, 0, 0, 1, 0, 6'd21, 8'h00);
      check_outputs("R9");
      check("R9 mode", 32'(mode_o), 32'd1);
      tick();
      set_pins(0, 0, 1, 1, 0, 6'd21, 8'h00);
      tick();
      read_at("R9", 6'd21, 8'hFF);

      // R1 erase and erase beating a write at the same edge
      set_pins(0, 1, 0, 1, 0, 6'd30, 8'h00);
      tick();
      set_pins(0, 1, 1, 1, 0, 6'd30, 8'h00);
      erase_i = 1'b1;
      tick();
      erase_i = 1'b0;
      read_at("R1", 6'd30, 8'hFF);
      read_at("R1", 6'd5, 8'hFF);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r;
         r = $urandom;
         set_pins(r[0] & r[1], r[2], r[3], r[4], r[5], AW'(r[8 +: 3]), 8'($urandom));
         erase_i = ($urandom_range(0, 60) == 0);
         check_outputs("R3 R5 R6 R7 R8 R9 random");
         tick();
         erase_i = 1'b0;
      end
      // R2 sweep reads after random writes
      for (int a = 0; a < 8; a++) begin
         read_at("R2 sweep", AW'(a), ref_mem[a]);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule